// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This block watches the running calendar time, held as BCD fields for second, minute, hour, date, month and day of week, and compares it against a programmed alarm. Each alarm byte carries its own enable in its top bit. A field whose enable is clear is left out of the compare, so the set of enabled fields decides how often the alarm repeats. The compare runs once per one-second tick, which arrives after the time has been updated. A match sets a sticky status flag and drives an active-low interrupt.

The interrupt has two modes. In level mode the interrupt follows the status flag and stays low until the host clears the flag. In pulse mode every match drives the interrupt low for a fixed count of 32.768 kHz enables, which is 250 ms at the default setting. A new match during a pulse starts the count again. The host can only clear the flag by writing zero. It can also ask for the flag to clear itself once a status read completes with a STOP. The whole alarm is held off while the frequency output function owns the interrupt pin.

Top module: `alarm_match`

## Requirements
- R1: A field takes part in the compare only when bit 7 of its alarm byte is 1. It then matches when bits 6:0 of the alarm byte equal bits 6:0 of the current field. A field with bit 7 at 0 always matches.
- R2: A match event happens only in a cycle where `tick_1hz_i` is 1, `alarm_en_i` is 1, `fout_active_i` is 0 and every field matches. Outside such a cycle the flag is never set.
- R3: A match event sets `alarm_flag_o` to 1 on the next clock edge, in either interrupt mode.
- R4: In level mode (`pulse_mode_i` = 0), `irq_no` is 0 while the flag is 1 and the alarm is enabled. It returns to 1 in the cycle after the flag is cleared.
- R5: In pulse mode (`pulse_mode_i` = 1), `irq_no` goes to 0 after a match event. It stays 0 until `PULSE_TICKS` cycles with `tick_32k_i` = 1 have passed, then returns to 1 even if the flag is still set.
- R6: A match event during an active pulse restarts the pulse count from `PULSE_TICKS`.
- R7: A status write with `sts_wr_data_i` = 0 clears the flag. A status write with `sts_wr_data_i` = 1 leaves the flag unchanged.
- R8: With `auto_clr_i` = 1, a status read framed by `sts_rd_start_i` and then `sts_rd_done_i` clears a flag that was set when the read started. With `auto_clr_i` = 0 the read leaves the flag set.
- R9: If a match event falls between `sts_rd_start_i` and `sts_rd_done_i`, the flag is still 1 after the read completes, even with auto-clear on.
- R10: While `fout_active_i` is 1 or `alarm_en_i` is 0, `irq_no` is 1, no match event occurs, and any running pulse is cancelled.
- R11: After reset, `alarm_flag_o` is 0 and `irq_no` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_1hz_i | input | 1 | One-cycle strobe, once per second, after the time update |
| tick_32k_i | input | 1 | One-cycle enable at 32.768 kHz |
| cur_sec_i | input | 8 | Current seconds, BCD |
| cur_min_i | input | 8 | Current minutes, BCD |
| cur_hour_i | input | 8 | Current hours, BCD |
| cur_date_i | input | 8 | Current date, BCD |
| cur_mon_i | input | 8 | Current month, BCD |
| cur_dow_i | input | 8 | Current day of week |
| alm_sec_i | input | 8 | Alarm seconds; bit 7 is the field enable |
| alm_min_i | input | 8 | Alarm minutes; bit 7 is the field enable |
| alm_hour_i | input | 8 | Alarm hours; bit 7 is the field enable |
| alm_date_i | input | 8 | Alarm date; bit 7 is the field enable |
| alm_mon_i | input | 8 | Alarm month; bit 7 is the field enable |
| alm_dow_i | input | 8 | Alarm day of week; bit 7 is the field enable |
| alarm_en_i | input | 1 | Master alarm enable |
| pulse_mode_i | input | 1 | 0 selects level mode, 1 selects pulse mode |
| auto_clr_i | input | 1 | Clear the flag after a completed status read |
| fout_active_i | input | 1 | Frequency output owns the pin; alarm held off |
| sts_wr_i | input | 1 | Status write strobe |
| sts_wr_data_i | input | 1 | Value written to the flag bit |
| sts_rd_start_i | input | 1 | Status read begins |
| sts_rd_done_i | input | 1 | Status read completed with STOP |
| alarm_flag_o | output | 1 | Sticky alarm status flag |
| irq_no | output | 1 | Interrupt, active low |

## Verification
The bench builds the block with `PULSE_TICKS` set to 16 instead of 8192. This puts both the end of a pulse and a restart in the middle of a pulse within a few dozen driven 32 kHz enables. The exact cycle where the interrupt returns high can then be checked edge by edge. The field count and the position of the enable bit keep their default values, so the random field patterns cover every enabled-subset combination of the six fields.

// File: rtl/alarm_match_pkg.sv
package alarm_match_pkg;
  localparam int unsigned NUM_FIELDS = 6;
  localparam int unsigned FIELD_W    = 8;
  localparam int unsigned EN_BIT     = FIELD_W - 1;
  typedef logic [FIELD_W-1:0] field_t;
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp
  import alarm_match_pkg::*;
#(
  parameter int unsigned N = NUM_FIELDS
) (
  input  logic [N-1:0][FIELD_W-1:0] cur_i,
  input  logic [N-1:0][FIELD_W-1:0] alm_i,
  output logic                      all_hit_o
);
  logic [N-1:0] hit;

  for (genvar g = 0; g < N; g++) begin : g_field
    // a disabled field never blocks the match
    assign hit[g] = ~alm_i[g][EN_BIT] |
                    (alm_i[g][EN_BIT-1:0] == cur_i[g][EN_BIT-1:0]);
  end

  assign all_hit_o = &hit;
endmodule

// File: rtl/alarm_status.sv
module alarm_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic wr_clr_i,
  input  logic rd_start_i,
  input  logic rd_done_i,
  input  logic auto_clr_i,
  output logic flag_o
);
  logic flag_q, seen_q;

  // seen_q: flag was set when the read began, with no new match since
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      if (set_i)                                       flag_q <= 1'b1;
      else if (wr_clr_i)                               flag_q <= 1'b0;
      else if (rd_done_i && auto_clr_i && seen_q)      flag_q <= 1'b0;

      if (set_i)           seen_q <= 1'b0;
      else if (rd_start_i) seen_q <= flag_q;
      else if (rd_done_i)  seen_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  // R3
  set_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
  // R8
  no_auto_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_done_i && !auto_clr_i && !wr_clr_i && flag_q) |=> flag_q);
  // R2
  no_spurious_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_i |=> !$rose(flag_q));
endmodule

// File: rtl/alarm_pulse.sv
module alarm_pulse #(
  parameter int unsigned PULSE_TICKS = 8192
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kill_i,
  input  logic start_i,
  input  logic tick_i,
  output logic active_o
);
  localparam int unsigned CNT_W = $clog2(PULSE_TICKS + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_TICKS);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (kill_i)                 cnt_q <= '0;
    else if (start_i)                cnt_q <= LOAD;
    else if (tick_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);

  // R5
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LOAD);
  // R5
  hold_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !tick_i && !kill_i) |=> active_o);
  // R6
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !kill_i) |=> (cnt_q == LOAD));
  // R10
  kill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |=> !active_o);
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import alarm_match_pkg::*;
#(
  parameter int unsigned PULSE_TICKS = 8192
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_1hz_i,
  input  logic       tick_32k_i,
  input  logic [7:0] cur_sec_i,
  input  logic [7:0] cur_min_i,
  input  logic [7:0] cur_hour_i,
  input  logic [7:0] cur_date_i,
  input  logic [7:0] cur_mon_i,
  input  logic [7:0] cur_dow_i,
  input  logic [7:0] alm_sec_i,
  input  logic [7:0] alm_min_i,
  input  logic [7:0] alm_hour_i,
  input  logic [7:0] alm_date_i,
  input  logic [7:0] alm_mon_i,
  input  logic [7:0] alm_dow_i,
  input  logic       alarm_en_i,
  input  logic       pulse_mode_i,
  input  logic       auto_clr_i,
  input  logic       fout_active_i,
  input  logic       sts_wr_i,
  input  logic       sts_wr_data_i,
  input  logic       sts_rd_start_i,
  input  logic       sts_rd_done_i,
  output logic       alarm_flag_o,
  output logic       irq_no
);
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] cur_vec, alm_vec;
  logic all_hit, armed, match_evt, pulse_active, assert_irq;

  assign cur_vec = {cur_dow_i, cur_mon_i, cur_date_i, cur_hour_i, cur_min_i, cur_sec_i};
  assign alm_vec = {alm_dow_i, alm_mon_i, alm_date_i, alm_hour_i, alm_min_i, alm_sec_i};

  alarm_field_cmp #(.N(NUM_FIELDS)) i_cmp (
    .cur_i     (cur_vec),
    .alm_i     (alm_vec),
    .all_hit_o (all_hit)
  );

  assign armed     = alarm_en_i & ~fout_active_i;
  assign match_evt = tick_1hz_i & armed & all_hit;

  alarm_status i_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (match_evt),
    .wr_clr_i   (sts_wr_i & ~sts_wr_data_i),
    .rd_start_i (sts_rd_start_i),
    .rd_done_i  (sts_rd_done_i),
    .auto_clr_i (auto_clr_i),
    .flag_o     (alarm_flag_o)
  );

  alarm_pulse #(.PULSE_TICKS(PULSE_TICKS)) i_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .kill_i   (~armed),
    .start_i  (match_evt & pulse_mode_i),
    .tick_i   (tick_32k_i),
    .active_o (pulse_active)
  );

  assign assert_irq = armed & ((alarm_flag_o & ~pulse_mode_i) | pulse_active);
  assign irq_no     = ~assert_irq;

  // R7
  write_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_wr_i && sts_wr_data_i && !alarm_flag_o && !match_evt) |=> !alarm_flag_o);
  // R10
  held_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alarm_en_i || fout_active_i) |=> !$rose(alarm_flag_o));
  // R4
  level_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_evt && !pulse_mode_i) |=> (!irq_no || !armed || pulse_mode_i));
endmodule

// File: tb/test_alarm_match.sv
module test_alarm_match;
  localparam int unsigned PT = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_1hz = 0, tick_32k = 0;
  logic [7:0] cur [6];
  logic [7:0] alm [6];
  logic en = 0, pm = 0, ac = 0, fo = 0, wr = 0, wd = 0, rs = 0, rd = 0;
  logic flag, irq_n;
  int n_chk = 0, n_fail = 0;
  bit  done = 0;

  always #10 clk = ~clk;

  alarm_match #(.PULSE_TICKS(PT)) i_alarm_match (
    .clk_i(clk), .rst_ni(rst_n), .tick_1hz_i(tick_1hz), .tick_32k_i(tick_32k),
    .cur_sec_i(cur[0]), .cur_min_i(cur[1]), .cur_hour_i(cur[2]),
    .cur_date_i(cur[3]), .cur_mon_i(cur[4]), .cur_dow_i(cur[5]),
    .alm_sec_i(alm[0]), .alm_min_i(alm[1]), .alm_hour_i(alm[2]),
    .alm_date_i(alm[3]), .alm_mon_i(alm[4]), .alm_dow_i(alm[5]),
    .alarm_en_i(en), .pulse_mode_i(pm), .auto_clr_i(ac), .fout_active_i(fo),
    .sts_wr_i(wr), .sts_wr_data_i(wd), .sts_rd_start_i(rs), .sts_rd_done_i(rd),
    .alarm_flag_o(flag), .irq_no(irq_n)
  );

  function automatic bit fields_match();
    for (int i = 0; i < 6; i++)
      if (alm[i][7] && alm[i][6:0] != cur[i][6:0]) return 0;
    return 1;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic sec_tick();
    tick_1hz = 1; cyc(); tick_1hz = 0;
  endtask

  task automatic slow_ticks(int n);
    for (int i = 0; i < n; i++) begin tick_32k = 1; cyc(); tick_32k = 0; end
  endtask

  task automatic clr();
    wr = 1; wd = 0; cyc(); wr = 0;
  endtask

  task automatic set_match_sec(logic [6:0] v);
    for (int i = 0; i < 6; i++) alm[i] = 8'h00;
    alm[0] = {1'b1, v}; cur[0] = {1'b0, v};
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int exp_cnt;
    logic exp_flag;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 6; i++) begin cur[i] = 0; alm[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R11 flag", flag, 1'b0);
    chk("R11 irq", irq_n, 1'b1);
    rst_n = 1; cyc();

    // R1 disabled fields differ, enabled seconds equal -> match
    en = 1; set_match_sec(7'h25);
    for (int i = 1; i < 6; i++) begin alm[i] = 8'h11; cur[i] = 8'h22; end
    sec_tick();
    chk("R1 disabled fields", flag, 1'b1);
    chk("R4 level irq low", irq_n, 1'b0);
    clr();
    chk("R4 irq high after clear", irq_n, 1'b1);
    chk("R7 write zero clears", flag, 1'b0);
    // R1 one enabled mismatching field blocks
    alm[3] = 8'h91; cur[3] = 8'h12; sec_tick();
    chk("R1 enabled mismatch", flag, 1'b0);
    // R2 no tick, no event
    alm[3] = 8'h00; repeat (3) cyc();
    chk("R2 no tick", flag, 1'b0);

    // R7 write one has no effect
    wr = 1; wd = 1; cyc(); wr = 0;
    chk("R7 write one on clear flag", flag, 1'b0);
    sec_tick();
    wr = 1; wd = 1; cyc(); wr = 0;
    chk("R7 write one on set flag", flag, 1'b1);

    // R8 auto clear
    ac = 1; rs = 1; cyc(); rs = 0; rd = 1; cyc(); rd = 0;
    chk("R8 auto clear", flag, 1'b0);
    sec_tick(); ac = 0;
    rs = 1; cyc(); rs = 0; rd = 1; cyc(); rd = 0;
    chk("R8 no auto clear", flag, 1'b1);
    // R9 match during read
    clr(); ac = 1; sec_tick();
    rs = 1; cyc(); rs = 0; sec_tick(); rd = 1; cyc(); rd = 0;
    chk("R9 match during read", flag, 1'b1);
    ac = 0; clr();

    // R5 pulse length
    pm = 1; sec_tick();
    chk("R3 pulse mode sets flag", flag, 1'b1);
    chk("R5 pulse starts", irq_n, 1'b0);
    slow_ticks(PT - 1);
    chk("R5 pulse before end", irq_n, 1'b0);
    slow_ticks(1);
    chk("R5 pulse ends", irq_n, 1'b1);
    chk("R5 flag stays", flag, 1'b1);
    // R6 restart
    sec_tick(); slow_ticks(10); sec_tick(); slow_ticks(PT - 1);
    chk("R6 restart holds low", irq_n, 1'b0);
    slow_ticks(1);
    chk("R6 restart ends", irq_n, 1'b1);

    // R10 fout and disable
    clr(); sec_tick(); fo = 1; cyc();
    chk("R10 fout cancels pulse", irq_n, 1'b1);
    clr(); sec_tick();
    chk("R10 fout blocks match", flag, 1'b0);
    fo = 0; en = 0; sec_tick();
    chk("R10 disabled blocks match", flag, 1'b0);
    chk("R10 disabled irq high", irq_n, 1'b1);
    en = 1; pm = 0; cyc();

    // random section
    exp_flag = flag; exp_cnt = 0;
    for (int it = 0; it < 400; it++) begin
      logic hit;
      for (int i = 0; i < 6; i++) begin
        alm[i] = {1'($urandom_range(0, 1)), 7'($urandom_range(0, 3))};
        cur[i] = {1'b0, 7'($urandom_range(0, 3))};
      end
      en = ($urandom_range(0, 9) != 0);
      fo = ($urandom_range(0, 9) == 0);
      pm = 1'($urandom_range(0, 1));
      hit = fields_match() && en && !fo;
      sec_tick();
      if (!en || fo) exp_cnt = 0;
      if (hit) begin exp_flag = 1; if (pm) exp_cnt = PT; end
      chk("R2 R3 random flag", flag, exp_flag);
      chk("R4 R5 random irq", irq_n,
          !(((exp_flag && !pm) || exp_cnt != 0) && en && !fo));
      if ($urandom_range(0, 2) == 0) begin clr(); exp_flag = 0; end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule